// File: doc/BRIEF.md
# Reorder Buffer with In-Order Retirement

This block is a circular queue that holds speculative results between out-of-order execution and in-order retirement. The dispatch side claims the slot at the tail of the queue and gets that slot's index back. Several writeback ports can finish entries in any order. Each port names a slot by its index and stores either a result value or a fault flag there, and the slot becomes done. The retire side looks only at the oldest entry. A done entry without a fault is presented on the architectural register file write port and freed. A done entry with a fault raises a one-cycle trap request and stays in place.

A flush input discards every speculative entry in one cycle by moving the tail back onto the head. Each pointer carries one extra wrap bit, so a full queue and an empty queue can be told apart without a separate counter. The rename stage uses an associative lookup port. It returns the youngest live entry that targets a given logical register, together with whether that entry's value is available yet. Several live entries may name the same destination register at once.

Top module: `retire_queue`

## Requirements
- R1: After reset the queue is empty, `alloc_ready` is 1, `alloc_idx` is 0, and neither `commit_en` nor `trap_req` is asserted.
- R2: An accepted allocation writes its PC and destination into slot `alloc_idx`. `alloc_idx` then advances by one, modulo DEPTH, with slots handed out in the order 0, 1, 2, ...
- R3: When DEPTH entries are live, `full` is 1 and `alloc_ready` is 0, and an allocation request changes nothing. `empty` is 1 exactly when no entry is live.
- R4: Writeback may finish entries in any order. A younger done entry never retires while the head entry is not done, and an empty queue never asserts `commit_en` or `trap_req`.
- R5: When the head entry is done and has no fault, and no flush is applied, `commit_en` is 1 for one cycle with the head's destination register and value. The head then advances, and at most one entry retires per cycle.
- R6: When the head entry is done with its fault flag set, `trap_req` is 1 for exactly one cycle and `trap_pc` carries that entry's PC. The entry is not freed and nothing behind it retires until a flush.
- R7: A flush sets the tail equal to the head. In the next cycle the queue is empty and `alloc_idx` equals the index of the old head. A flush cycle accepts no allocation and retires nothing.
- R8: `lookup_hit` is 1 when some live entry targets `lookup_reg`. `lookup_idx` then names the youngest such entry, `lookup_ready` reports whether that entry is done, and `lookup_value` gives its value when it is done.
- R9: Allocating a slot clears its done and fault flags, so a reused slot never shows a result left by its previous occupant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Dispatch requests a new entry |
| alloc_pc | input | PC_W | PC of the dispatched instruction |
| alloc_dst | input | REG_W | Logical destination register |
| alloc_ready | output | 1 | A free slot exists |
| alloc_idx | output | IDX_W | Index of the tail slot |
| wb_valid | input | WB_PORTS | Per-port writeback strobe |
| wb_idx | input | WB_PORTS*IDX_W | Per-port target slot, port p at bits [p*IDX_W +: IDX_W] |
| wb_value | input | WB_PORTS*DATA_W | Per-port result value |
| wb_fault | input | WB_PORTS | Per-port fault flag |
| commit_en | output | 1 | Architectural register file write strobe |
| commit_dst | output | REG_W | Register written at retirement |
| commit_value | output | DATA_W | Value written at retirement |
| trap_req | output | 1 | One-cycle handler request for a faulting head |
| trap_pc | output | PC_W | PC of the faulting head |
| flush | input | 1 | Discard all speculative entries |
| full | output | 1 | DEPTH entries are live |
| empty | output | 1 | No entry is live |
| lookup_reg | input | REG_W | Logical register being looked up |
| lookup_hit | output | 1 | A live entry targets lookup_reg |
| lookup_idx | output | IDX_W | Youngest matching slot |
| lookup_ready | output | 1 | The matching slot is done |
| lookup_value | output | DATA_W | The matching slot's value |

## Verification
The bench targets out-of-order writeback where younger entries finish first. A design that retired any done entry rather than the head would send results to the register file in the wrong order. It also fills the queue and then asks for one more slot. Without the wrap bit the design would mistake the full queue for an empty one and overwrite the head. A faulting head is left in place for several cycles: a design that freed the entry would retire younger work past the fault, and one that re-raised the request would invoke the handler repeatedly. A slot whose earlier result was done is reused after a flush, and a long randomized phase mixes flushes, faults and repeated destination registers. These target lookups that return stale data or an older definition, and pointers that drift across the wrap point.

// File: rtl/retire_queue.sv
module retire_queue #(
  parameter int DEPTH    = 8,
  parameter int PC_W     = 32,
  parameter int DATA_W   = 32,
  parameter int REG_W    = 5,
  parameter int WB_PORTS = 2,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_valid,
  input  logic [PC_W-1:0]            alloc_pc,
  input  logic [REG_W-1:0]           alloc_dst,
  output logic                       alloc_ready,
  output logic [IDX_W-1:0]           alloc_idx,
  input  logic [WB_PORTS-1:0]        wb_valid,
  input  logic [WB_PORTS*IDX_W-1:0]  wb_idx,
  input  logic [WB_PORTS*DATA_W-1:0] wb_value,
  input  logic [WB_PORTS-1:0]        wb_fault,
  output logic                       commit_en,
  output logic [REG_W-1:0]           commit_dst,
  output logic [DATA_W-1:0]          commit_value,
  output logic                       trap_req,
  output logic [PC_W-1:0]            trap_pc,
  input  logic                       flush,
  output logic                       full,
  output logic                       empty,
  input  logic [REG_W-1:0]           lookup_reg,
  output logic                       lookup_hit,
  output logic [IDX_W-1:0]           lookup_idx,
  output logic                       lookup_ready,
  output logic [DATA_W-1:0]          lookup_value
);
  localparam int PTR_W = IDX_W + 1;

  logic [PC_W-1:0]   pc_q  [DEPTH];
  logic [REG_W-1:0]  dst_q [DEPTH];
  logic [DATA_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0]  done_q, fault_q;
  logic [PTR_W-1:0]  head_ptr, tail_ptr, used;
  logic [IDX_W-1:0]  head_idx, tail_idx;
  logic              trap_sent, head_done, alloc_fire;

  assign head_idx    = head_ptr[IDX_W-1:0];
  assign tail_idx    = tail_ptr[IDX_W-1:0];
  assign used        = tail_ptr - head_ptr;
  assign empty       = (used == '0);
  assign full        = (used == PTR_W'(DEPTH));
  assign alloc_ready = !full;
  assign alloc_idx   = tail_idx;
  assign alloc_fire  = alloc_valid && !full && !flush;

  assign head_done    = !empty && done_q[head_idx];
  assign commit_en    = head_done && !fault_q[head_idx] && !flush;
  assign commit_dst   = dst_q[head_idx];
  assign commit_value = val_q[head_idx];
  assign trap_req     = head_done && fault_q[head_idx] && !trap_sent;
  assign trap_pc      = pc_q[head_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_ptr  <= '0;
      tail_ptr  <= '0;
      trap_sent <= 1'b0;
    end else if (flush) begin
      tail_ptr  <= head_ptr;
      trap_sent <= 1'b0;
    end else begin
      if (commit_en)  head_ptr  <= head_ptr + 1'b1;
      if (alloc_fire) tail_ptr  <= tail_ptr + 1'b1;
      if (trap_req)   trap_sent <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q  <= '0;
      fault_q <= '0;
    end else begin
      for (int p = 0; p < WB_PORTS; p++) begin
        if (wb_valid[p]) begin
          done_q[wb_idx[p*IDX_W +: IDX_W]]  <= 1'b1;
          fault_q[wb_idx[p*IDX_W +: IDX_W]] <= wb_fault[p];
        end
      end
      if (alloc_fire) begin
        done_q[tail_idx]  <= 1'b0;
        fault_q[tail_idx] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int p = 0; p < WB_PORTS; p++)
      if (wb_valid[p]) val_q[wb_idx[p*IDX_W +: IDX_W]] <= wb_value[p*DATA_W +: DATA_W];
    if (alloc_fire) begin
      pc_q[tail_idx]  <= alloc_pc;
      dst_q[tail_idx] <= alloc_dst;
    end
  end

  always_comb begin
    lookup_hit = 1'b0;
    lookup_idx = head_idx;
    for (int k = 0; k < DEPTH; k++) begin
      if (PTR_W'(k) < used && dst_q[head_idx + IDX_W'(k)] == lookup_reg) begin
        lookup_hit = 1'b1;
        lookup_idx = head_idx + IDX_W'(k);
      end
    end
  end

  assign lookup_ready = lookup_hit && done_q[lookup_idx];
  assign lookup_value = val_q[lookup_idx];
endmodule

// File: rtl/retire_queue_chk.sv
module retire_queue_chk #(
  parameter int DEPTH  = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic             flush,
  input logic             full,
  input logic             empty,
  input logic             commit_en,
  input logic             trap_req,
  input logic [IDX_W-1:0] alloc_idx,
  input logic [IDX_W-1:0] head_idx
);
  assert_alloc_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready && !flush) |=> (alloc_idx == $past(alloc_idx) + IDX_W'(1)));

  assert_full_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !commit_en && !flush) |=> full);

  assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (!commit_en && !trap_req));

  assert_head_steps_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (head_idx == $past(head_idx) + IDX_W'(1)));

  assert_head_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit_en && trap_req));

  assert_trap_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |=> !trap_req);

  assert_flush_empties_R7: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

bind retire_queue retire_queue_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
  .flush(flush), .full(full), .empty(empty), .commit_en(commit_en),
  .trap_req(trap_req), .alloc_idx(alloc_idx), .head_idx(head_idx)
);

// File: tb/retire_queue_tb.sv
module retire_queue_tb;
  localparam int DEPTH = 8, PC_W = 32, DATA_W = 32, REG_W = 5, WBP = 2, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                  alloc_valid, alloc_ready;
  logic [PC_W-1:0]       alloc_pc;
  logic [REG_W-1:0]      alloc_dst;
  logic [IW-1:0]         alloc_idx;
  logic [WBP-1:0]        wb_valid, wb_fault;
  logic [WBP*IW-1:0]     wb_idx;
  logic [WBP*DATA_W-1:0] wb_value;
  logic                  commit_en, trap_req, flush, full, empty;
  logic [REG_W-1:0]      commit_dst, lookup_reg;
  logic [DATA_W-1:0]     commit_value, lookup_value;
  logic [PC_W-1:0]       trap_pc;
  logic                  lookup_hit, lookup_ready;
  logic [IW-1:0]         lookup_idx;

  retire_queue #(.DEPTH(DEPTH), .PC_W(PC_W), .DATA_W(DATA_W), .REG_W(REG_W), .WB_PORTS(WBP)) u_dut (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_pc(alloc_pc), .alloc_dst(alloc_dst),
    .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .wb_valid(wb_valid), .wb_idx(wb_idx),
    .wb_value(wb_value), .wb_fault(wb_fault), .commit_en(commit_en), .commit_dst(commit_dst),
    .commit_value(commit_value), .trap_req(trap_req), .trap_pc(trap_pc), .flush(flush),
    .full(full), .empty(empty), .lookup_reg(lookup_reg), .lookup_hit(lookup_hit),
    .lookup_idx(lookup_idx), .lookup_ready(lookup_ready), .lookup_value(lookup_value)
  );

  int m_head, m_tail;
  logic [PC_W-1:0]   m_pc  [DEPTH];
  logic [REG_W-1:0]  m_dst [DEPTH];
  logic [DATA_W-1:0] m_val [DEPTH];
  bit m_done [DEPTH];
  bit m_fault [DEPTH];
  bit m_trap_sent, x_commit, x_trap, finished;
  int checks = 0, errors = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic compare();
    int cnt, h, li;
    bit hit;
    cnt = m_tail - m_head;
    h   = m_head % DEPTH;
    hit = 0;
    li  = 0;
    x_commit = cnt > 0 && m_done[h] && !m_fault[h] && !flush;
    x_trap   = cnt > 0 && m_done[h] && m_fault[h] && !m_trap_sent;
    chk("R3 full", full, cnt == DEPTH);
    chk("R3 alloc_ready", alloc_ready, cnt != DEPTH);
    chk("R3 empty", empty, cnt == 0);
    chk("R2 alloc_idx", alloc_idx, m_tail % DEPTH);
    chk("R5 commit_en", commit_en, x_commit);
    if (x_commit) begin
      chk("R5 commit_dst", commit_dst, m_dst[h]);
      chk("R5 commit_value", commit_value, m_val[h]);
    end
    chk("R6 trap_req", trap_req, x_trap);
    if (x_trap) chk("R6 trap_pc", trap_pc, m_pc[h]);
    for (int k = 0; k < cnt; k++) begin
      int s;
      s = (m_head + k) % DEPTH;
      if (m_dst[s] == lookup_reg) begin
        hit = 1;
        li  = s;
      end
    end
    chk("R8 lookup_hit", lookup_hit, hit);
    if (hit) begin
      chk("R8 lookup_idx", lookup_idx, li);
      chk("R8 lookup_ready", lookup_ready, m_done[li]);
      if (m_done[li]) chk("R8 lookup_value", lookup_value, m_val[li]);
    end
  endtask

  task automatic update();
    int t;
    bit room;
    t    = m_tail % DEPTH;
    room = (m_tail - m_head) != DEPTH;
    if (flush) begin
      m_tail = m_head;
      m_trap_sent = 0;
    end else begin
      if (x_commit) m_head++;
      if (x_trap) m_trap_sent = 1;
    end
    for (int p = 0; p < WBP; p++) begin
      if (wb_valid[p]) begin
        int s;
        s = int'(wb_idx[p*IW +: IW]);
        m_val[s]   = wb_value[p*DATA_W +: DATA_W];
        m_done[s]  = 1;
        m_fault[s] = wb_fault[p];
      end
    end
    if (!flush && alloc_valid && room) begin
      m_pc[t] = alloc_pc;
      m_dst[t] = alloc_dst;
      m_done[t] = 0;
      m_fault[t] = 0;
      m_tail++;
    end
  endtask

  task automatic step();
    #1 compare();
    @(posedge clk);
    update();
    @(negedge clk);
    alloc_valid = 0;
    wb_valid = '0;
    wb_fault = '0;
    flush = 0;
  endtask

  task automatic set_wb(int p, int idx, logic [DATA_W-1:0] v, bit f);
    wb_valid[p] = 1'b1;
    wb_idx[p*IW +: IW] = IW'(idx);
    wb_value[p*DATA_W +: DATA_W] = v;
    wb_fault[p] = f;
  endtask

  task automatic set_alloc(logic [PC_W-1:0] pc, logic [REG_W-1:0] d);
    alloc_valid = 1;
    alloc_pc = pc;
    alloc_dst = d;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    alloc_valid = 0; alloc_pc = '0; alloc_dst = '0;
    wb_valid = '0; wb_fault = '0; wb_idx = '0; wb_value = '0;
    flush = 0; lookup_reg = '0;
    m_head = 0; m_tail = 0; m_trap_sent = 0; finished = 0;
    for (int i = 0; i < DEPTH; i++) begin
      m_done[i] = 0; m_fault[i] = 0; m_dst[i] = '0; m_val[i] = '0; m_pc[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;

    #1;
    chk("R1 empty after reset", empty, 1);
    chk("R1 alloc_ready after reset", alloc_ready, 1);
    chk("R1 alloc_idx after reset", alloc_idx, 0);
    chk("R1 no commit after reset", commit_en, 0);
    chk("R1 no trap after reset", trap_req, 0);

    lookup_reg = 5'd2;
    for (int i = 0; i < DEPTH + 1; i++) begin
      set_alloc(32'h100 + 32'(4 * i), REG_W'(i % 3 + 1));
      step();
    end
    #1;
    chk("R3 full after filling", full, 1);
    chk("R3 refused allocation keeps tail", alloc_idx, 0);

    set_wb(0, 3, 32'h33, 0);
    set_wb(1, 1, 32'h11, 0);
    step();
    #1 chk("R4 younger done entries wait for head", commit_en, 0);
    set_wb(0, 0, 32'hAA, 0);
    step();
    step();
    step();
    set_wb(1, 2, 32'h22, 0);
    step();
    lookup_reg = 5'd1;
    set_alloc(32'h200, 5'd1);
    step();
    step();
    step();

    set_wb(0, 4, 32'h0, 1);
    set_wb(1, 5, 32'h55, 0);
    step();
    step();
    #1;
    chk("R6 trap only once", trap_req, 0);
    chk("R6 faulting head blocks retirement", commit_en, 0);
    chk("R6 faulting head not freed", empty, 0);
    step();
    step();
    flush = 1;
    step();
    #1;
    chk("R7 empty after flush", empty, 1);
    chk("R7 tail returns to head slot", alloc_idx, 4);

    set_alloc(32'h300, 5'd7);
    step();
    lookup_reg = 5'd9;
    set_alloc(32'h304, 5'd9);
    step();
    #1;
    chk("R9 reused slot found", lookup_hit, 1);
    chk("R9 reused slot index", lookup_idx, 5);
    chk("R9 reused slot not done", lookup_ready, 0);
    step();

    for (int c = 0; c < 3000; c++) begin
      int cnt;
      cnt = m_tail - m_head;
      if ($urandom % 10 < 6) set_alloc($urandom, REG_W'($urandom % 8));
      for (int p = 0; p < WBP; p++)
        if (cnt > 0 && $urandom % 2 == 1)
          set_wb(p, (m_head + int'($urandom % cnt)) % DEPTH, $urandom, ($urandom % 40) == 0);
      flush = ($urandom % 60) == 0;
      lookup_reg = REG_W'($urandom % 8);
      step();
    end

    if (!finished) begin
      finished = 1;
      finish_run();
    end
  end
endmodule